// File: doc/BRIEF.md
# 40-bit Shift, Rotate and Bit-Field Unit

This block is the shift stage of a fixed-point datapath. Each cycle it can take one operation on a 40-bit operand and return the answer one clock later together with zero and sign flags. It covers the following operations:

- arithmetic and logical shifts by a signed distance;
- rotation across all 40 bits;
- sign-bit exponent detection on the low 32 bits, used to normalise a value before rounding;
- extraction of a bit field, with zero or sign extension;
- insertion of a bit field into an otherwise unchanged word;
- a ones count.

The issuing stage presents an op code, the operand, a shift distance, a field descriptor (start bit and width) and an insert source, and raises `in_valid`. The block has no handshake: it accepts a new operation every cycle. When no operation is issued, the last answer stays on the outputs.

Top module: `shf40_unit`

## Requirements
- R1: While `rst_n` is low and after its release until the first issued operation, `out_valid`, `result`, `flag_zero` and `flag_neg` are all 0.
- R2: An operation issued with `in_valid` high at a clock edge appears on `result` after that edge with `out_valid` high; in a cycle with `in_valid` low, `out_valid` goes to 0 and `result` and the flags keep their previous values.
- R3: Op code 0 is an arithmetic shift: `amount` is two's complement (-32..31); a positive value shifts left with zero fill, a negative value shifts right by its magnitude with copies of bit 39.
- R4: Op code 1 is a logical shift: positive `amount` shifts left and negative `amount` shifts right, with zero fill in both directions.
- R5: Op code 2 is a rotation over all 40 bits: positive `amount` rotates toward bit 39 and negative `amount` rotates toward bit 0. An amount of 0 returns the operand unchanged.
- R6: Op code 3 returns, zero-extended, the number of bits below bit 31 of `operand[31:0]` that equal bit 31, counted downward until the first differing bit. The result is 31 for all-zero and all-one words.
- R7: Op code 4 returns `fld_len` bits of `operand` starting at bit `fld_pos`; source bits above bit 39 read as 0. When `fld_sext` is 1 and `fld_len` is nonzero, the top bit of the field is copied into all higher bits; otherwise those bits are 0. A width of 0 returns 0.
- R8: Op code 5 returns `operand` with bits `fld_pos` to `fld_pos+fld_len-1` replaced by the low `fld_len` bits of `dep_src`. Field bits above bit 39 are dropped, and every bit outside the field is left unchanged.
- R9: Op code 6 returns the number of 1 bits in `operand`, in the range 0..40.
- R10: With each issued result, `flag_zero` is 1 exactly when the 40-bit result is 0, and `flag_neg` equals bit 39 of the result.
- R11: Op code 7 is reserved and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issues the operation on the inputs |
| op | input | 3 | Operation code (0..7) |
| operand | input | 40 | Value to operate on |
| amount | input | 6 | Signed shift or rotate distance |
| fld_pos | input | 5 | Start bit of the field |
| fld_len | input | 5 | Width of the field in bits |
| fld_sext | input | 1 | Sign-extend the extracted field |
| dep_src | input | 40 | Source bits for field insertion |
| out_valid | output | 1 | Result of the previous cycle's issue is present |
| result | output | 40 | Registered result |
| flag_zero | output | 1 | Result equals zero |
| flag_neg | output | 1 | Bit 39 of the result |

## Verification
Two kinds of event can land on the same edge. One is replacing the previous result with a new one while a different operation is already presented. The other is retiring the last issued result while the unit goes idle, so that the output must hold. The vector table is driven with `in_valid` high on every cycle, and the op changes from one vector to the next, for example a rotation directly after a logical shift. Each sampled result is compared only with its own vector's expected value, so any value carried over from the previous operation shows up as a mismatch. Immediately after an issue the unit is made idle while the operand and op are changed; the held result and a low `out_valid` are then compared against the value issued one cycle earlier.

// File: rtl/shf40_pkg.sv
package shf40_pkg;

    typedef enum logic [2:0] {
        OP_ASH = 3'd0,
        OP_LSH = 3'd1,
        OP_ROT = 3'd2,
        OP_EXP = 3'd3,
        OP_EXT = 3'd4,
        OP_DEP = 3'd5,
        OP_POP = 3'd6,
        OP_RSV = 3'd7
    } shf_op_e;

endpackage

// File: rtl/shf40_shift.sv
module shf40_shift #(
    parameter int W  = 40,
    parameter int AW = 6
) (
    input  logic [W-1:0]  x,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    input  logic          rotate,
    output logic [W-1:0]  y
);
    localparam int KW = $clog2(W) + 1;

    logic [AW-1:0]  mag;
    logic           go_left;
    logic [KW-1:0]  rot_k;
    logic [2*W-1:0] dbl;

    always_comb begin
        go_left = !amt[AW-1];
        mag     = go_left ? amt : (~amt + 1'b1);
        rot_k   = go_left ? KW'(mag) : (KW'(W) - KW'(mag));
        dbl     = {x, x} << rot_k;
        if (rotate) begin
            y = dbl[2*W-1:W];
        end else if (go_left) begin
            y = x << mag;
        end else if (arith) begin
            y = $unsigned($signed(x) >>> mag);
        end else begin
            y = x >> mag;
        end
    end

endmodule

// File: rtl/shf40_field.sv
module shf40_field #(
    parameter int W  = 40,
    parameter int PW = 5
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  dep,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] len,
    input  logic          sext,
    output logic [W-1:0]  ext_y,
    output logic [W-1:0]  dep_y
);
    logic [W-1:0] mask;
    logic [W-1:0] win;
    logic [W-1:0] placed;
    logic         top_bit;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(len));
        end
        win     = x >> pos;
        top_bit = (len != '0) ? win[len - 1'b1] : 1'b0;
        ext_y   = win & mask;
        if (sext && top_bit) begin
            ext_y = ext_y | ~mask;
        end
        placed = mask << pos;
        dep_y  = (x & ~placed) | ((dep << pos) & placed);
    end

endmodule

// File: rtl/shf40_count.sv
module shf40_count #(
    parameter int W  = 40,
    parameter int EW = 32
) (
    input  logic [W-1:0]               x,
    output logic [$clog2(EW)-1:0]      lead,
    output logic [$clog2(W+1)-1:0]     ones
);
    localparam int LW = $clog2(EW);
    localparam int CW = $clog2(W + 1);

    logic run;

    always_comb begin
        lead = '0;
        run  = 1'b1;
        for (int i = EW - 2; i >= 0; i--) begin
            if (run && (x[i] == x[EW-1])) begin
                lead = lead + LW'(1);
            end else begin
                run = 1'b0;
            end
        end
        ones = '0;
        for (int j = 0; j < W; j++) begin
            ones = ones + CW'(x[j]);
        end
    end

endmodule

// File: rtl/shf40_unit.sv
module shf40_unit
    import shf40_pkg::*;
#(
    parameter int W  = 40,
    parameter int AW = 6,
    parameter int PW = 5,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] amount,
    input  logic [PW-1:0] fld_pos,
    input  logic [PW-1:0] fld_len,
    input  logic          fld_sext,
    input  logic [W-1:0]  dep_src,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          flag_zero,
    output logic          flag_neg
);
    localparam int LW = $clog2(EW);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] res;
        logic         zero;
        logic         neg;
    } stage_t;

    stage_t  st_d, st_q;
    shf_op_e op_e;

    logic [W-1:0]  shift_y, ext_y, dep_y;
    logic [LW-1:0] lead_cnt;
    logic [CW-1:0] ones_cnt;
    logic [W-1:0]  pick;

    assign op_e = shf_op_e'(op);

    shf40_shift #(.W(W), .AW(AW)) u_shift (
        .x      (operand),
        .amt    (amount),
        .arith  (op_e == OP_ASH),
        .rotate (op_e == OP_ROT),
        .y      (shift_y)
    );

    shf40_field #(.W(W), .PW(PW)) u_field (
        .x     (operand),
        .dep   (dep_src),
        .pos   (fld_pos),
        .len   (fld_len),
        .sext  (fld_sext),
        .ext_y (ext_y),
        .dep_y (dep_y)
    );

    shf40_count #(.W(W), .EW(EW)) u_count (
        .x    (operand),
        .lead (lead_cnt),
        .ones (ones_cnt)
    );

    always_comb begin
        case (op_e)
            OP_ASH, OP_LSH, OP_ROT: pick = shift_y;
            OP_EXP:                 pick = W'(lead_cnt);
            OP_EXT:                 pick = ext_y;
            OP_DEP:                 pick = dep_y;
            OP_POP:                 pick = W'(ones_cnt);
            default:                pick = '0;
        endcase
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res  = pick;
            st_d.zero = (pick == '0);
            st_d.neg  = pick[W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign flag_zero = st_q.zero;
    assign flag_neg  = st_q.neg;

    assert_issue_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_zero)));

    assert_rot_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && amount == '0) |=> (result == $past(operand)));

    assert_exp_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3) |=> (result < W'(EW)));

    assert_pop_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=> (result <= W'(W)));

    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> (result == '0 && flag_zero));

endmodule

// File: tb/sim_shf40_unit.sv
module sim_shf40_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [39:0] operand = '0;
    logic [5:0]  amount = '0;
    logic [4:0]  fld_pos = '0;
    logic [4:0]  fld_len = '0;
    logic        fld_sext = 1'b0;
    logic [39:0] dep_src = '0;
    logic        out_valid;
    logic [39:0] result;
    logic        flag_zero;
    logic        flag_neg;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    shf40_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .operand(operand), .amount(amount), .fld_pos(fld_pos),
        .fld_len(fld_len), .fld_sext(fld_sext), .dep_src(dep_src),
        .out_valid(out_valid), .result(result),
        .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    // {op, amount, pos, len, sext, operand, dep_src, expected}
    localparam int NV = 18;
    localparam logic [139:0] VEC [NV] = '{
        {3'd0, 6'h04, 5'd0,  5'd0,  1'b0, 40'h00000000F1, 40'h0, 40'h0000000F10},
        {3'd0, 6'h3C, 5'd0,  5'd0,  1'b0, 40'h8000000010, 40'h0, 40'hF800000001},
        {3'd1, 6'h3C, 5'd0,  5'd0,  1'b0, 40'h8000000010, 40'h0, 40'h0800000001},
        {3'd1, 6'h1F, 5'd0,  5'd0,  1'b0, 40'h0000000003, 40'h0, 40'h0180000000},
        {3'd2, 6'h08, 5'd0,  5'd0,  1'b0, 40'hAB00000001, 40'h0, 40'h00000001AB},
        {3'd2, 6'h3C, 5'd0,  5'd0,  1'b0, 40'h0000000001, 40'h0, 40'h1000000000},
        {3'd3, 6'h00, 5'd0,  5'd0,  1'b0, 40'h0000000000, 40'h0, 40'h000000001F},
        {3'd3, 6'h00, 5'd0,  5'd0,  1'b0, 40'hFFFFFFFFFF, 40'h0, 40'h000000001F},
        {3'd3, 6'h00, 5'd0,  5'd0,  1'b0, 40'h0000000100, 40'h0, 40'h0000000016},
        {3'd3, 6'h00, 5'd0,  5'd0,  1'b0, 40'h00C0000000, 40'h0, 40'h0000000001},
        {3'd4, 6'h00, 5'd8,  5'd8,  1'b0, 40'h000000A500, 40'h0, 40'h00000000A5},
        {3'd4, 6'h00, 5'd8,  5'd8,  1'b1, 40'h000000A500, 40'h0, 40'hFFFFFFFFA5},
        {3'd4, 6'h00, 5'd4,  5'd0,  1'b1, 40'hFFFFFFFFFF, 40'h0, 40'h0000000000},
        {3'd5, 6'h00, 5'd4,  5'd8,  1'b0, 40'hFFFFFFFFFF, 40'h0, 40'hFFFFFFF00F},
        {3'd5, 6'h00, 5'd30, 5'd16, 1'b0, 40'h0000000000, 40'h000000FFFF, 40'hFFC0000000},
        {3'd6, 6'h00, 5'd0,  5'd0,  1'b0, 40'hFFFFFFFFFF, 40'h0, 40'h0000000028},
        {3'd6, 6'h00, 5'd0,  5'd0,  1'b0, 40'h8000000001, 40'h0, 40'h0000000002},
        {3'd7, 6'h00, 5'd0,  5'd0,  1'b0, 40'h123456789A, 40'h0, 40'h0000000000}
    };

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [139:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        op       = v[139:137];
        amount   = v[136:131];
        fld_pos  = v[130:126];
        fld_len  = v[125:121];
        fld_sext = v[120];
        operand  = v[119:80];
        dep_src  = v[79:40];
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {36'd0, out_valid, flag_zero, flag_neg, 1'b0}, 40'h0);
        chk("R1", result, 40'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", {38'd0, out_valid, flag_zero}, 40'h0);

        // vector table, issued back to back
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i]);
            @(posedge clk);
            #1;
            chk(tag_of(VEC[i][139:137]), result, VEC[i][39:0]);
            chk("R2", {39'd0, out_valid}, 40'h1);
            chk("R10", {38'd0, flag_zero, flag_neg},
                {38'd0, (VEC[i][39:0] == 40'h0), VEC[i][39]});
        end

        // R2: issue then idle with changed inputs; result must hold
        issue({3'd6, 6'h00, 5'd0, 5'd0, 1'b0, 40'h000000000F, 40'h0, 40'h4});
        @(posedge clk);
        #1;
        chk("R9", result, 40'h4);
        @(negedge clk);
        in_valid = 1'b0;
        op       = 3'd2;
        operand  = 40'hFFFFFFFFFF;
        amount   = 6'h05;
        @(posedge clk);
        #1;
        chk("R2", result, 40'h4);
        chk("R2", {38'd0, out_valid, flag_zero}, 40'h0);

        // R5: rotation by zero leaves operand intact
        issue({3'd2, 6'h00, 5'd0, 5'd0, 1'b0, 40'hC3000000A5, 40'h0, 40'h0});
        @(posedge clk);
        #1;
        chk("R5", result, 40'hC3000000A5);
        chk("R10", {38'd0, flag_zero, flag_neg}, 40'h1);

        // R8: deposit only touches field bits
        issue({3'd5, 6'h00, 5'd16, 5'd4, 1'b0, 40'h123456789A, 40'hFFFFFFFFF5, 40'h0});
        @(posedge clk);
        #1;
        chk("R8", result, 40'h123455789A);

        // R3: most negative amount, arithmetic right by 32
        issue({3'd0, 6'h20, 5'd0, 5'd0, 1'b0, 40'h8000000000, 40'h0, 40'h0});
        @(posedge clk);
        #1;
        chk("R3", result, 40'hFFFFFFFF80);

        @(negedge clk);
        in_valid = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule